// File: doc/BRIEF.md
# I2C Message Sequencer

This block runs one I2C master message on a status-coded controller without a processor. When `start` is accepted, it latches the target address, the mode flags and the byte count. It then issues control and data register writes to the controller. On every controller event, it decodes the 8-bit status code and picks the next step: a START, a first or second address byte, a data byte, a receive-and-continue, or a STOP. Address bytes are formed in hardware for both 7-bit and ten-bit targets. The direction bit is the read flag XOR the reverse-direction flag.

Write data arrives on a valid/ready stream, and read data leaves on a valid/ready stream. A pending data send waits while `wr_valid` is low; `wr_ready` stays high and no register write is made during that time. A received byte is held on `rd_data`, and `rd_valid` stays high until `rd_ready` is seen. The controller is only told to continue once the byte has been taken.

The message ends with a one-cycle `done` pulse and a 2-bit error code. An abort input, or an optional cycle-count timeout, sends the sequencer into an aborting state. In that state the next controller event only produces a STOP.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `wr_ready`, `rd_valid` and both register write strobes are low. Data register writes occur only while `busy` is high.
- R2: Control register bits are: ACK at bit 2, STOP at bit 4, START at bit 5, bus enable at bit 6 and interrupt enable at bit 7.
  - An accepted `start` writes control 0xE4 in the cycle after it is sampled.
  - Status 0x08 or 0x10 writes the first address byte to the data register, with control 0xC4.
  - In 7-bit mode, the first address byte is {addr[6:0], dir}.
- R3: In ten-bit mode, the first address byte is {5'b11110, addr[9:8], dir}. Status 0x18 or 0x40 then writes addr[7:0] as the second address byte.
- R4: The direction bit is `rd_op` XOR `rev_dir`.
- R5: Status 0x18 (7-bit mode), 0xD0 or 0x28 sends the next write byte if any remain. Otherwise it writes control STOP (0x50 | ACK<<2), and `done` pulses in the following cycle with error 0.
- R6: On a read, status 0x50 presents the captured byte on `rd_data` and decrements the count.
  - When one byte remains after a decision, the ACK bit is written as 0.
  - Status 0x58 presents the byte and writes STOP.
- R7: Status 0x20, 0x30 or 0x48 writes STOP and ends with error code 1 (no device).
- R8: Any status not listed in R2 to R7 writes STOP and ends with error code 2 (I/O error).
- R9: With `no_start` set, the START and address phases are skipped.
  - A read writes control 0xC4 at once and waits for data.
  - A write sends its first byte at once.
- R10: A read of zero length writes STOP directly on its address-ACK status (0x40 or 0xE0).
- R11: `abort_req` during a message sets error 2 and makes the next event write STOP and end the message.
  - An event arriving while no message is active writes STOP without a `done` pulse.
- R12: With nonzero `timeout_cycles`, a message still active that many cycles after it began aborts with error code 3. The next event writes STOP.
- R13: `wr_ready` or `rd_valid` held without its partner suppresses every register write. `rd_data` stays stable until `rd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a message (ignored while busy) |
| abort_req | input | 1 | Abandon the current message |
| tgt_addr | input | 10 | Target address |
| ten_bit | input | 1 | Ten-bit addressing |
| rd_op | input | 1 | Read message |
| rev_dir | input | 1 | Invert the direction bit |
| no_start | input | 1 | Skip START and address phases |
| byte_len | input | LEN_W | Byte count |
| timeout_cycles | input | TO_W | Timeout limit, 0 disables |
| ctl_event | input | 1 | Controller event strobe |
| ctl_status | input | 8 | Controller status code |
| ctl_data_rdata | input | 8 | Controller data register value |
| ctl_data_we | output | 1 | Data register write strobe |
| ctl_data_wdata | output | 8 | Data register write value |
| ctl_ctrl_we | output | 1 | Control register write strobe |
| ctl_ctrl_wdata | output | 8 | Control register write value |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte wanted |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle end-of-message pulse |
| err | output | 2 | 0 none, 1 no device, 2 I/O, 3 timeout |

## Verification
An event or start sampled at one rising edge produces its register write strobes in the cycle right after that edge, provided no stream handshake stalls it. The STOP write is followed one cycle later by `done` and the final error code.

The bench drives inputs on falling edges and samples at the falling edge after the sampling edge, so strobes are read in their single valid cycle. For stalled actions, it raises the missing valid or ready on a falling edge, waits one time unit, and checks the strobe while the combinational fire is asserted. The timeout check waits well past the limit before presenting the next event.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WSTART, ST_WA1, ST_WA2, ST_WSACK, ST_WSDATA, ST_ABORT
  } seq_st_e;

  typedef enum logic [2:0] {
    AC_CONT, AC_START, AC_A1, AC_A2, AC_DATA, AC_RCV, AC_RCV_STOP, AC_STOP
  } seq_act_e;

  typedef enum logic [1:0] {ER_NONE, ER_NODEV, ER_IO, ER_TIMEOUT} seq_err_e;

  localparam logic [7:0] SC_START    = 8'h08;
  localparam logic [7:0] SC_RSTART   = 8'h10;
  localparam logic [7:0] SC_WA_ACK   = 8'h18;
  localparam logic [7:0] SC_WA_NACK  = 8'h20;
  localparam logic [7:0] SC_WD_ACK   = 8'h28;
  localparam logic [7:0] SC_WD_NACK  = 8'h30;
  localparam logic [7:0] SC_RA_ACK   = 8'h40;
  localparam logic [7:0] SC_RA_NACK  = 8'h48;
  localparam logic [7:0] SC_RD_ACK   = 8'h50;
  localparam logic [7:0] SC_RD_NACK  = 8'h58;
  localparam logic [7:0] SC_WA2_ACK  = 8'hD0;
  localparam logic [7:0] SC_RA2_ACK  = 8'hE0;

  localparam int CB_ACK   = 2;
  localparam int CB_STOP  = 4;
  localparam int CB_START = 5;
  localparam int CB_EN    = 6;
  localparam int CB_IEN   = 7;
endpackage

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr (
  input  logic [9:0] addr,
  input  logic       ten,
  input  logic       rd,
  input  logic       rev,
  output logic [7:0] a1,
  output logic [7:0] a2
);
  logic dir;
  assign dir = rd ^ rev;
  assign a1  = ten ? {5'b11110, addr[9:8], dir} : {addr[6:0], dir};
  assign a2  = ten ? addr[7:0] : 8'h00;
endmodule

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);
  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (clear)               cnt <= '0;
    else if (run && cnt != '1)    cnt <= cnt + 1'b1;
  end

  assign expired = run && (limit != '0) && (cnt >= limit);
endmodule

// File: rtl/i2c_seq_decide.sv
module i2c_seq_decide
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  seq_st_e          st,
  input  logic [7:0]       status,
  input  logic             ten,
  input  logic [LEN_W-1:0] cnt,
  input  logic             ack,
  output seq_st_e          nst,
  output seq_act_e         nact,
  output logic [LEN_W-1:0] ncnt,
  output logic             nack,
  output logic             set_err,
  output seq_err_e         nerr
);
  logic wr_path, rd_path;

  always_comb begin
    nst = st; nact = AC_STOP; ncnt = cnt; nack = ack;
    set_err = 1'b0; nerr = ER_NONE;
    wr_path = 1'b0; rd_path = 1'b0;
    if (st == ST_IDLE) begin
      nact = AC_STOP;
    end else if (st == ST_ABORT) begin
      nact = AC_STOP; nst = ST_IDLE;
    end else begin
      case (status)
        SC_START, SC_RSTART: begin nact = AC_A1; nst = ST_WA1; end
        SC_WA_ACK: if (ten) begin nact = AC_A2; nst = ST_WA2; end
                   else wr_path = 1'b1;
        SC_WA2_ACK, SC_WD_ACK: wr_path = 1'b1;
        SC_RA_ACK: if (ten) begin nact = AC_A2; nst = ST_WA2; end
                   else rd_path = 1'b1;
        SC_RA2_ACK: rd_path = 1'b1;
        SC_RD_ACK: begin
          nact = AC_RCV; nst = ST_WSDATA;
          if (cnt != '0) ncnt = cnt - 1'b1;
          if (cnt == LEN_W'(2)) nack = 1'b0;
        end
        SC_RD_NACK: begin nact = AC_RCV_STOP; nst = ST_IDLE; end
        SC_WA_NACK, SC_WD_NACK, SC_RA_NACK: begin
          nact = AC_STOP; nst = ST_IDLE; set_err = 1'b1; nerr = ER_NODEV;
        end
        default: begin
          nact = AC_STOP; nst = ST_IDLE; set_err = 1'b1; nerr = ER_IO;
        end
      endcase
      if (wr_path) begin
        if (cnt != '0) begin nact = AC_DATA; nst = ST_WSACK; ncnt = cnt - 1'b1; end
        else begin nact = AC_STOP; nst = ST_IDLE; end
      end
      if (rd_path) begin
        if (cnt == '0) begin nact = AC_STOP; nst = ST_IDLE; end
        else begin
          nact = AC_CONT; nst = ST_WSDATA;
          if (cnt == LEN_W'(1)) nack = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort_req,
  input  logic [9:0]       tgt_addr,
  input  logic             ten_bit,
  input  logic             rd_op,
  input  logic             rev_dir,
  input  logic             no_start,
  input  logic [LEN_W-1:0] byte_len,
  input  logic [TO_W-1:0]  timeout_cycles,
  input  logic             ctl_event,
  input  logic [7:0]       ctl_status,
  input  logic [7:0]       ctl_data_rdata,
  output logic             ctl_data_we,
  output logic [7:0]       ctl_data_wdata,
  output logic             ctl_ctrl_we,
  output logic [7:0]       ctl_ctrl_wdata,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err
);
  seq_st_e          st, nst;
  seq_act_e         act, nact;
  seq_err_e         err_q, nerr;
  logic             pend, ack, nack, set_err, ten_q;
  logic [LEN_W-1:0] cnt, ncnt;
  logic [7:0]       a1_q, a2_q, a1_w, a2_w, rbuf;
  logic             accept, take_ev, active, tmo, fire, is_stop, is_rcv;
  logic [7:0]       ctrl_norm, ctrl_stop;

  i2c_seq_addr u_addr (
    .addr(tgt_addr), .ten(ten_bit), .rd(rd_op), .rev(rev_dir), .a1(a1_w), .a2(a2_w)
  );

  i2c_seq_decide #(.LEN_W(LEN_W)) u_decide (
    .st(st), .status(ctl_status), .ten(ten_q), .cnt(cnt), .ack(ack),
    .nst(nst), .nact(nact), .ncnt(ncnt), .nack(nack), .set_err(set_err), .nerr(nerr)
  );

  assign active = busy && (st != ST_IDLE) && (st != ST_ABORT);

  i2c_seq_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(active),
    .limit(timeout_cycles), .expired(tmo)
  );

  assign accept  = start && !busy && !pend;
  assign take_ev = ctl_event && !pend && !accept;
  assign is_stop = (act == AC_STOP) || (act == AC_RCV_STOP);
  assign is_rcv  = (act == AC_RCV) || (act == AC_RCV_STOP);

  assign wr_ready = pend && (act == AC_DATA);
  assign rd_valid = pend && is_rcv;
  assign rd_data  = rbuf;
  assign fire     = pend && ((act == AC_DATA) ? wr_valid : (is_rcv ? rd_ready : 1'b1));

  always_comb begin
    ctrl_norm = 8'h00;
    ctrl_norm[CB_IEN] = 1'b1;
    ctrl_norm[CB_EN]  = 1'b1;
    ctrl_norm[CB_ACK] = ack;
    ctrl_stop = 8'h00;
    ctrl_stop[CB_EN]   = 1'b1;
    ctrl_stop[CB_STOP] = 1'b1;
    ctrl_stop[CB_ACK]  = ack;
  end

  always_comb begin
    ctl_ctrl_we    = fire;
    ctl_data_we    = fire && ((act == AC_A1) || (act == AC_A2) || (act == AC_DATA));
    ctl_data_wdata = (act == AC_A1) ? a1_q : (act == AC_A2) ? a2_q : wr_data;
    if (is_stop)              ctl_ctrl_wdata = ctrl_stop;
    else if (act == AC_START) ctl_ctrl_wdata = ctrl_norm | (8'h01 << CB_START);
    else                      ctl_ctrl_wdata = ctrl_norm;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; act <= AC_STOP; pend <= 1'b0; cnt <= '0; ack <= 1'b1;
      err_q <= ER_NONE; busy <= 1'b0; done <= 1'b0; rbuf <= 8'h00;
      a1_q <= 8'h00; a2_q <= 8'h00; ten_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fire) begin
        pend <= 1'b0;
        if (is_stop && busy) begin done <= 1'b1; busy <= 1'b0; end
      end
      if (accept) begin
        busy <= 1'b1; err_q <= ER_NONE; ack <= 1'b1; cnt <= byte_len;
        a1_q <= a1_w; a2_q <= a2_w; ten_q <= ten_bit; pend <= 1'b1;
        if (!no_start) begin
          st <= ST_WSTART; act <= AC_START;
        end else if (rd_op) begin
          st <= ST_WSDATA; act <= AC_CONT;
        end else if (byte_len != '0) begin
          st <= ST_WSACK; act <= AC_DATA; cnt <= byte_len - 1'b1;
        end else begin
          st <= ST_IDLE; act <= AC_STOP;
        end
      end else if (take_ev) begin
        st <= nst; act <= nact; cnt <= ncnt; ack <= nack; pend <= 1'b1;
        if (set_err) err_q <= nerr;
        if ((nact == AC_RCV) || (nact == AC_RCV_STOP)) rbuf <= ctl_data_rdata;
      end else if (abort_req && active) begin
        st <= ST_ABORT; err_q <= ER_IO;
      end else if (tmo) begin
        st <= ST_ABORT; err_q <= ER_TIMEOUT;
      end
    end
  end

  assign err = err_q;
endmodule

// File: rtl/i2c_msg_sequencer_chk.sv
module i2c_msg_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_data_we,
  input logic       ctl_ctrl_we,
  input logic [7:0] ctl_ctrl_wdata,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       busy,
  input logic       done
);
  assert_data_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_data_we |-> busy);

  assert_wr_stall_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |-> !ctl_ctrl_we);

  assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_done_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ctl_ctrl_we && ctl_ctrl_wdata[4]));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind i2c_msg_sequencer i2c_msg_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_data_we(ctl_data_we), .ctl_ctrl_we(ctl_ctrl_we),
  .ctl_ctrl_wdata(ctl_ctrl_wdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .busy(busy), .done(done)
);

// File: tb/i2c_msg_sequencer_tb.sv
module i2c_msg_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 8;
  localparam int TO_W  = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort_req = 1'b0;
  logic [9:0] tgt_addr = '0;
  logic ten_bit = 1'b0, rd_op = 1'b0, rev_dir = 1'b0, no_start = 1'b0;
  logic [LEN_W-1:0] byte_len = '0;
  logic [TO_W-1:0] timeout_cycles = '0;
  logic ctl_event = 1'b0;
  logic [7:0] ctl_status = 8'h00, ctl_data_rdata = 8'h00;
  logic ctl_data_we, ctl_ctrl_we, wr_ready, rd_valid, busy, done;
  logic [7:0] ctl_data_wdata, ctl_ctrl_wdata, rd_data;
  logic wr_valid = 1'b1, rd_ready = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] err;

  int vectors = 0, fails = 0, cycles = 0;
  bit reported = 0;

  i2c_msg_sequencer #(.LEN_W(LEN_W), .TO_W(TO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort_req(abort_req),
    .tgt_addr(tgt_addr), .ten_bit(ten_bit), .rd_op(rd_op), .rev_dir(rev_dir),
    .no_start(no_start), .byte_len(byte_len), .timeout_cycles(timeout_cycles),
    .ctl_event(ctl_event), .ctl_status(ctl_status), .ctl_data_rdata(ctl_data_rdata),
    .ctl_data_we(ctl_data_we), .ctl_data_wdata(ctl_data_wdata),
    .ctl_ctrl_we(ctl_ctrl_we), .ctl_ctrl_wdata(ctl_ctrl_wdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      vectors++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      report();
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic go(input logic [9:0] a, input logic ten, input logic rd, input logic rev,
                    input logic ns, input logic [LEN_W-1:0] len);
    @(negedge clk);
    tgt_addr = a; ten_bit = ten; rd_op = rd; rev_dir = rev; no_start = ns; byte_len = len;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic ev(input logic [7:0] s, input logic [7:0] rdv);
    @(negedge clk);
    ctl_event = 1'b1; ctl_status = s; ctl_data_rdata = rdv;
    @(negedge clk);
    ctl_event = 1'b0;
  endtask

  task automatic expect_end(input string req, input logic [1:0] e);
    @(negedge clk);
    chk(req, "done", 8'(done), 8'h01);
    chk(req, "err", 8'(err), 8'(e));
    chk(req, "busy", 8'(busy), 8'h00);
  endtask

  task automatic t_reset();
    chk("R1", "busy", 8'(busy), 8'h00);
    chk("R1", "done", 8'(done), 8'h00);
    chk("R1", "ctrl_we", 8'(ctl_ctrl_we), 8'h00);
    chk("R1", "data_we", 8'(ctl_data_we), 8'h00);
    chk("R1", "wr_ready", 8'(wr_ready), 8'h00);
    chk("R1", "rd_valid", 8'(rd_valid), 8'h00);
  endtask

  task automatic t_idle_event();
    ev(8'h28, 8'h00);
    chk("R11", "idle ctrl", ctl_ctrl_wdata, 8'h54);
    chk("R11", "idle ctrl_we", 8'(ctl_ctrl_we), 8'h01);
    chk("R11", "idle data_we", 8'(ctl_data_we), 8'h00);
    @(negedge clk);
    chk("R11", "idle no done", 8'(done), 8'h00);
  endtask

  task automatic t_write7();
    go(10'h05A, 0, 0, 0, 0, 8'd2);
    chk("R2", "start ctrl", ctl_ctrl_wdata, 8'hE4);
    chk("R2", "start data_we", 8'(ctl_data_we), 8'h00);
    ev(8'h08, 8'h00);
    chk("R2", "a1 byte", ctl_data_wdata, 8'hB4);
    chk("R2", "a1 ctrl", ctl_ctrl_wdata, 8'hC4);
    wr_data = 8'hA1;
    ev(8'h18, 8'h00);
    chk("R5", "byte0", ctl_data_wdata, 8'hA1);
    chk("R5", "byte0 we", 8'(ctl_data_we), 8'h01);
    wr_data = 8'h3B;
    ev(8'h28, 8'h00);
    chk("R5", "byte1", ctl_data_wdata, 8'h3B);
    ev(8'h28, 8'h00);
    chk("R5", "stop ctrl", ctl_ctrl_wdata, 8'h54);
    chk("R5", "stop data_we", 8'(ctl_data_we), 8'h00);
    expect_end("R5", 2'd0);
  endtask

  task automatic t_rev();
    go(10'h012, 0, 0, 1, 0, 8'd0);
    ev(8'h10, 8'h00);
    chk("R4", "rev a1", ctl_data_wdata, 8'h25);
    ev(8'h18, 8'h00);
    chk("R4", "empty write stop", ctl_ctrl_wdata, 8'h54);
    expect_end("R4", 2'd0);
  endtask

  task automatic t_read10();
    go(10'h2A5, 1, 1, 0, 0, 8'd2);
    ev(8'h08, 8'h00);
    chk("R3", "ten a1", ctl_data_wdata, 8'hF5);
    ev(8'h40, 8'h00);
    chk("R3", "ten a2", ctl_data_wdata, 8'hA5);
    chk("R3", "ten a2 we", 8'(ctl_data_we), 8'h01);
    ev(8'hE0, 8'h00);
    chk("R6", "continue ctrl", ctl_ctrl_wdata, 8'hC4);
    chk("R6", "continue data_we", 8'(ctl_data_we), 8'h00);
    ev(8'h50, 8'h11);
    chk("R6", "rd_valid", 8'(rd_valid), 8'h01);
    chk("R6", "rd byte0", rd_data, 8'h11);
    chk("R6", "ack cleared", ctl_ctrl_wdata, 8'hC0);
    ev(8'h58, 8'h22);
    chk("R6", "rd byte1", rd_data, 8'h22);
    chk("R6", "last stop", ctl_ctrl_wdata, 8'h50);
    expect_end("R6", 2'd0);
  endtask

  task automatic t_nodev();
    go(10'h033, 0, 0, 0, 0, 8'd1);
    ev(8'h08, 8'h00);
    ev(8'h20, 8'h00);
    chk("R7", "nack stop", ctl_ctrl_wdata, 8'h54);
    expect_end("R7", 2'd1);
    go(10'h033, 0, 1, 0, 0, 8'd1);
    ev(8'h08, 8'h00);
    ev(8'h48, 8'h00);
    chk("R7", "rd nack stop", ctl_ctrl_wdata, 8'h54);
    expect_end("R7", 2'd1);
  endtask

  task automatic t_ioerr();
    go(10'h033, 0, 0, 0, 0, 8'd1);
    ev(8'h08, 8'h00);
    ev(8'h38, 8'h00);
    chk("R8", "odd status stop", ctl_ctrl_wdata, 8'h54);
    expect_end("R8", 2'd2);
  endtask

  task automatic t_nostart();
    wr_data = 8'h9E;
    go(10'h011, 0, 0, 0, 1, 8'd2);
    chk("R9", "ns write data_we", 8'(ctl_data_we), 8'h01);
    chk("R9", "ns write byte", ctl_data_wdata, 8'h9E);
    chk("R9", "ns write ctrl", ctl_ctrl_wdata, 8'hC4);
    wr_data = 8'h4D;
    ev(8'h28, 8'h00);
    chk("R9", "ns write byte1", ctl_data_wdata, 8'h4D);
    ev(8'h28, 8'h00);
    expect_end("R9", 2'd0);
    go(10'h011, 0, 1, 0, 1, 8'd1);
    chk("R9", "ns read ctrl", ctl_ctrl_wdata, 8'hC4);
    chk("R9", "ns read data_we", 8'(ctl_data_we), 8'h00);
    ev(8'h58, 8'h77);
    chk("R9", "ns read byte", rd_data, 8'h77);
    chk("R9", "ns read stop", ctl_ctrl_wdata, 8'h54);
    expect_end("R9", 2'd0);
  endtask

  task automatic t_zero_rd();
    go(10'h040, 0, 1, 0, 0, 8'd0);
    ev(8'h08, 8'h00);
    chk("R10", "rd a1", ctl_data_wdata, 8'h81);
    ev(8'h40, 8'h00);
    chk("R10", "zero stop", ctl_ctrl_wdata, 8'h54);
    chk("R10", "zero no data", 8'(ctl_data_we), 8'h00);
    expect_end("R10", 2'd0);
  endtask

  task automatic t_abort();
    go(10'h033, 0, 0, 0, 0, 8'd3);
    ev(8'h08, 8'h00);
    @(negedge clk); abort_req = 1'b1;
    @(negedge clk); abort_req = 1'b0;
    ev(8'h18, 8'h00);
    chk("R11", "abort stop", ctl_ctrl_wdata, 8'h54);
    chk("R11", "abort no data", 8'(ctl_data_we), 8'h00);
    expect_end("R11", 2'd2);
  endtask

  task automatic t_timeout();
    timeout_cycles = 16'd20;
    go(10'h033, 0, 0, 0, 0, 8'd1);
    for (int i = 0; i < 40; i++) @(negedge clk);
    chk("R12", "still busy", 8'(busy), 8'h01);
    ev(8'h08, 8'h00);
    chk("R12", "timeout stop", ctl_ctrl_wdata, 8'h54);
    chk("R12", "timeout no data", 8'(ctl_data_we), 8'h00);
    expect_end("R12", 2'd3);
    timeout_cycles = 16'd0;
  endtask

  task automatic t_bp_wr();
    wr_valid = 1'b0;
    go(10'h033, 0, 0, 0, 0, 8'd1);
    ev(8'h08, 8'h00);
    ev(8'h18, 8'h00);
    chk("R13", "wr_ready", 8'(wr_ready), 8'h01);
    chk("R13", "stall no ctrl", 8'(ctl_ctrl_we), 8'h00);
    @(negedge clk);
    chk("R13", "stall hold", 8'(ctl_ctrl_we), 8'h00);
    wr_data = 8'h66; wr_valid = 1'b1;
    #1;
    chk("R13", "release we", 8'(ctl_data_we), 8'h01);
    chk("R13", "release byte", ctl_data_wdata, 8'h66);
    ev(8'h28, 8'h00);
    expect_end("R13", 2'd0);
  endtask

  task automatic t_bp_rd();
    rd_ready = 1'b0;
    go(10'h033, 0, 1, 0, 0, 8'd1);
    ev(8'h08, 8'h00);
    ev(8'h40, 8'h00);
    chk("R6", "single read ack off", ctl_ctrl_wdata, 8'hC0);
    ev(8'h58, 8'h3C);
    chk("R13", "rd_valid held", 8'(rd_valid), 8'h01);
    chk("R13", "rd stall no ctrl", 8'(ctl_ctrl_we), 8'h00);
    @(negedge clk);
    chk("R13", "rd data stable", rd_data, 8'h3C);
    rd_ready = 1'b1;
    #1;
    chk("R13", "rd release ctrl", ctl_ctrl_wdata, 8'h50);
    chk("R13", "rd release we", 8'(ctl_ctrl_we), 8'h01);
    expect_end("R13", 2'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_event();
    t_write7();
    t_rev();
    t_read10();
    t_nodev();
    t_ioerr();
    t_nostart();
    t_zero_rd();
    t_abort();
    t_timeout();
    t_bp_wr();
    t_bp_rd();
    repeat (2) @(negedge clk);
    report();
  end
endmodule